// File: doc/BRIEF.md
# Completion Status Poller

This block runs on the host side of a parallel flash bus. After software or a sequencer has written a program or erase command to the memory, a single `start` pulse hands this block the value that bit 7 should carry once the operation is over, along with an address inside the region being written. For a program, that value is the programmed bit 7. For an erase, it is 1. The block then reads that address over and over through a request/acknowledge read port until the status byte settles or the operation is reported as failed.

A status byte whose bit 7 equals the expected value counts as a match. The block does not trust the other seven bits of the matching read, because bit 7 can settle before them, so it performs one more read and returns that byte as the final data. Bit 5 set on a non-matching read marks an internal timeout. Bit 7 and bit 5 can flip in the same instant, so on a timeout the block reads once more and decides from that read alone. A poll budget set by a parameter limits how long a device that never answers can keep the block busy.

The result sits on `done`, `pass` and `final_data`. It stays there until the next accepted start.

Top module: `status_poll_ctrl`

## Requirements
- R1: A `start` in idle captures `exp_bit7` and `poll_addr`. Every read of that run presents the captured address on `rd_addr`. A `start` while a run is active has no effect on the address or on the sequence of reads.
- R2: `rd_req` is high whenever a run is active and low in idle. A read completes in a cycle where `rd_req` and `rd_ack` are both high, and `rd_data` is sampled in that cycle. While a read waits for `rd_ack`, `rd_addr` holds steady.
- R3: A poll read with bit 7 of `rd_data` equal to the expected value is followed by exactly one confirmation read. The run then ends with `done`=1, `pass`=1 and `final_data` equal to the byte from the confirmation read.
- R4: A poll read with bit 7 different from the expected value and bit 5 equal to 0 is followed by another poll read.
- R5: A poll read with bit 7 different from the expected value and bit 5 equal to 1 is followed by exactly one re-check read. If bit 7 of the re-check read matches, one confirmation read follows and the run passes as in R3. If it does not match, the run ends with `done`=1 and `pass`=0, and no further read is made.
- R6: With `exp_bit7`=1 (erase), status bytes that show bit 7 = 0 keep the loop going, and the first byte with bit 7 = 1 counts as a match.
- R7: If `MAX_POLLS` consecutive poll reads each show a mismatch with bit 5 = 0, the run ends with `done`=1 and `pass`=0 right after the `MAX_POLLS`-th read. A match on that last read still takes the R3 path.
- R8: On a failed run, `final_data` holds the byte from the last read.
- R9: `done`, `pass` and `final_data` keep their values until the next accepted `start`. That start clears `done` and `pass`. `pass` is never 1 while `done` is 0.
- R10: After reset, `done`=0, `pass`=0, `rd_req`=0 and `final_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin polling |
| exp_bit7 | input | 1 | Expected bit 7 when finished (programmed bit, or 1 for erase) |
| poll_addr | input | ADDR_W | Address to poll |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read completes in this cycle |
| rd_data | input | 8 | Status byte returned by the read |
| done | output | 1 | Run finished; held until the next start |
| pass | output | 1 | Run succeeded; valid while done is high |
| final_data | output | 8 | Confirmation byte on pass, last byte read on fail |

## Verification
The poll loop is driven with scripted status byte sequences that separate the decision paths:
- a program whose bit 7 stays complemented for a few reads before it matches;
- an erase that reads 0 and then 1;
- a timeout read whose re-check matches;
- a timeout read whose re-check does not match;
- a stream that never changes.

Counting the reads the bench device serves, and checking the confirmation byte that comes back, shows whether the extra read after a match and the extra read after a timeout really happen. The budget boundary is tried twice: once with a match on the very last allowed read and once with no match at all, which distinguishes the match-first priority from an off-by-one in the poll count.

// File: rtl/status_poll_pkg.sv
// Shared types for the completion status poller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package status_poll_pkg;

    // Phase of a polling run; the phase tells what the current read is for.
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_POLL,
        PH_RECHECK,
        PH_CONFIRM
    } poll_phase_e;

    // Decision taken when a read completes.
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_RETRY,
        ACT_RECHECK,
        ACT_CONFIRM,
        ACT_PASS,
        ACT_FAIL
    } poll_act_e;

endpackage

// File: rtl/poll_budget.sv
// Poll budget counter: counts the poll reads that neither matched nor
// timed out, and flags the read that uses up the budget.
// Assumes: MAX_POLLS >= 1; clr and inc are never high in the same cycle.
module poll_budget #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    logic [CNT_W-1:0] cnt_q;

    // Count retried polls; a new run clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The read now being judged is the final one the budget allows.
    always_comb begin
        last = (cnt_q == CNT_W'(MAX_POLLS - 1));
    end
endmodule

// File: rtl/poll_decide.sv
// Decision logic: turns a completed read, the current phase and the budget
// state into the next action of the poll loop.
// Assumes: valid is high only in the cycle a read completes.
module poll_decide
    import status_poll_pkg::*;
(
    input  logic        valid,
    input  poll_phase_e phase,
    input  logic        flag_bit,
    input  logic        tmo_bit,
    input  logic        expect_bit,
    input  logic        budget_last,
    output poll_act_e   act
);
    logic hit;

    // Pick the action for this read; a match is checked before the timeout flag.
    always_comb begin
        hit = (flag_bit == expect_bit);
        act = ACT_NONE;
        if (valid) begin
            case (phase)
                PH_POLL: begin
                    if (hit)              act = ACT_CONFIRM;
                    else if (tmo_bit)     act = ACT_RECHECK;
                    else if (budget_last) act = ACT_FAIL;
                    else                  act = ACT_RETRY;
                end
                PH_RECHECK: act = hit ? ACT_CONFIRM : ACT_FAIL;
                PH_CONFIRM: act = ACT_PASS;
                default:    act = ACT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/status_poll_ctrl.sv
// Completion status poller, top level. It polls a flash status byte at one
// fixed address until bit FLAG_BIT equals the expected value, re-reads once
// after a timeout flag on bit TMO_BIT, confirms a match with one more read,
// and gives up after MAX_POLLS unanswered polls.
// Assumes: rd_data is valid in any cycle where rd_req and rd_ack are both high.
module status_poll_ctrl
    import status_poll_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 8,
    parameter int FLAG_BIT  = 7,
    parameter int TMO_BIT   = 5,
    parameter int MAX_POLLS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              exp_bit7,
    input  logic [ADDR_W-1:0] poll_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              pass,
    output logic [DATA_W-1:0] final_data
);
    poll_phase_e       phase_q;
    logic              exp_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_fire;
    logic              budget_last;
    logic              accept;
    poll_act_e         act;

    // A read completes, or a new run is accepted.
    always_comb begin
        rd_fire = rd_req && rd_ack;
        accept  = (phase_q == PH_IDLE) && start;
    end

    poll_budget #(
        .MAX_POLLS (MAX_POLLS)
    ) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (act == ACT_RETRY),
        .last  (budget_last)
    );

    poll_decide u_decide (
        .valid       (rd_fire),
        .phase       (phase_q),
        .flag_bit    (rd_data[FLAG_BIT]),
        .tmo_bit     (rd_data[TMO_BIT]),
        .expect_bit  (exp_q),
        .budget_last (budget_last),
        .act         (act)
    );

    // Phase sequencing, capture of the run inputs, and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            exp_q      <= 1'b0;
            addr_q     <= '0;
            done       <= 1'b0;
            pass       <= 1'b0;
            final_data <= '0;
        end else if (accept) begin
            phase_q <= PH_POLL;
            exp_q   <= exp_bit7;
            addr_q  <= poll_addr;
            done    <= 1'b0;
            pass    <= 1'b0;
        end else begin
            case (act)
                ACT_RECHECK: phase_q <= PH_RECHECK;
                ACT_CONFIRM: phase_q <= PH_CONFIRM;
                ACT_PASS: begin
                    phase_q    <= PH_IDLE;
                    done       <= 1'b1;
                    pass       <= 1'b1;
                    final_data <= rd_data;
                end
                ACT_FAIL: begin
                    phase_q    <= PH_IDLE;
                    done       <= 1'b1;
                    pass       <= 1'b0;
                    final_data <= rd_data;
                end
                default: phase_q <= phase_q;
            endcase
        end
    end

    // Drive the read port from the current phase and the captured address.
    always_comb begin
        rd_req  = (phase_q != PH_IDLE);
        rd_addr = addr_q;
    end
endmodule

// File: rtl/status_poll_chk.sv
// Port-level protocol checks for status_poll_ctrl, attached by bind.
// Assumes: the top module's parameters keep their default widths.
module status_poll_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic [DATA_W-1:0] rd_data,
    input logic              done,
    input logic              pass,
    input logic [DATA_W-1:0] final_data
);
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R2
    no_req_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);

    // R9
    pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(final_data)));

    // R8
    final_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(rd_ack) && final_data == $past(rd_data)));
endmodule

bind status_poll_ctrl status_poll_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_status_poll_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_ack     (rd_ack),
    .rd_data    (rd_data),
    .done       (done),
    .pass       (pass),
    .final_data (final_data)
);

// File: tb/test_status_poll_ctrl.sv
// Directed bench for status_poll_ctrl: a scripted device answers each read
// with the next byte of a per-test script and records the addresses it sees.
module test_status_poll_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 20;
    localparam int MAXP       = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              exp_bit7 = 1'b0;
    logic [ADDR_W-1:0] poll_addr = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ack = 1'b0;
    logic [7:0]        rd_data = 8'h00;
    logic              done;
    logic              pass;
    logic [7:0]        final_data;

    logic [7:0]        script [16];
    int                nreads = 0;
    logic [ADDR_W-1:0] want_addr = '0;
    int                addr_bad = 0;
    int                checks = 0;
    int                fails = 0;

    status_poll_ctrl #(
        .ADDR_W    (ADDR_W),
        .MAX_POLLS (MAXP)
    ) i_status_poll_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .exp_bit7   (exp_bit7),
        .poll_addr  (poll_addr),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data),
        .done       (done),
        .pass       (pass),
        .final_data (final_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Scripted device: acknowledges each request in alternate cycles.
    always @(negedge clk) begin
        if (rd_ack) begin
            rd_ack = 1'b0;
        end else if (rd_req) begin
            if (rd_addr != want_addr) addr_bad = addr_bad + 1;
            rd_data = (nreads < 16) ? script[nreads] : 8'h00;
            rd_ack  = 1'b1;
            nreads  = nreads + 1;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] fillv);
        for (int i = 0; i < 16; i++) script[i] = fillv;
    endtask

    task automatic launch(input logic e, input logic [ADDR_W-1:0] a);
        nreads = 0;
        addr_bad = 0;
        want_addr = a;
        @(negedge clk);
        exp_bit7 = e;
        poll_addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        poll_addr = ~a;
        exp_bit7 = ~e;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400 && !done; i++) @(negedge clk);
    endtask

    task automatic t_program();
        fill(8'h00);
        script[0] = 8'h80; script[1] = 8'h80; script[2] = 8'h12; script[3] = 8'h34;
        launch(1'b0, 20'h1A2B3);
        check("R9", "done cleared by start", int'(done), 0);
        check("R2", "rd_req active", int'(rd_req), 1);
        wait_done();
        check("R3", "program pass", int'(pass), 1);
        check("R3", "confirm byte", int'(final_data), 'h34);
        check("R4", "read count", nreads, 4);
        check("R1", "address errors", addr_bad, 0);
    endtask

    task automatic t_erase();
        fill(8'h00);
        script[0] = 8'h40; script[1] = 8'h00; script[2] = 8'h80; script[3] = 8'hFF;
        launch(1'b1, 20'h00400);
        wait_done();
        check("R6", "erase pass", int'(pass), 1);
        check("R6", "erase final", int'(final_data), 'hFF);
        check("R6", "erase reads", nreads, 4);
    endtask

    task automatic t_tmo_recover();
        fill(8'h00);
        script[0] = 8'h20; script[1] = 8'hA0; script[2] = 8'h5A;
        launch(1'b1, 20'h0F0F0);
        wait_done();
        check("R5", "recheck pass", int'(pass), 1);
        check("R5", "recheck final", int'(final_data), 'h5A);
        check("R5", "recheck reads", nreads, 3);
    endtask

    task automatic t_tmo_fail();
        fill(8'h00);
        script[0] = 8'h00; script[1] = 8'h20; script[2] = 8'h28;
        launch(1'b1, 20'h00010);
        wait_done();
        check("R5", "timeout fail", int'(pass), 0);
        check("R5", "timeout done", int'(done), 1);
        check("R8", "fail final", int'(final_data), 'h28);
        repeat (6) @(negedge clk);
        check("R5", "no read after fail", nreads, 3);
    endtask

    task automatic t_budget_fail();
        fill(8'h01);
        launch(1'b1, 20'h00777);
        wait_done();
        check("R7", "budget fail", int'(pass), 0);
        check("R7", "budget reads", nreads, MAXP);
        check("R8", "budget final", int'(final_data), 'h01);
        repeat (10) @(negedge clk);
        check("R9", "done held", int'(done), 1);
        check("R9", "final held", int'(final_data), 'h01);
        check("R2", "rd_req idle", int'(rd_req), 0);
    endtask

    task automatic t_budget_edge();
        fill(8'h01);
        script[MAXP-1] = 8'h81; script[MAXP] = 8'h66;
        launch(1'b1, 20'h00888);
        wait_done();
        check("R7", "match on last poll", int'(pass), 1);
        check("R7", "last poll reads", nreads, MAXP + 1);
        check("R7", "last poll final", int'(final_data), 'h66);
    endtask

    task automatic t_busy_start();
        fill(8'h00);
        script[4] = 8'h80; script[5] = 8'h3C;
        launch(1'b1, 20'h0ABCD);
        repeat (2) @(negedge clk);
        poll_addr = 20'h11111;
        exp_bit7 = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check("R1", "busy start addr", addr_bad, 0);
        check("R1", "busy start reads", nreads, 6);
        check("R1", "busy start result", int'(final_data), 'h3C);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        fill(8'h00);
        repeat (3) @(negedge clk);
        check("R10", "reset done", int'(done), 0);
        check("R10", "reset pass", int'(pass), 0);
        check("R10", "reset rd_req", int'(rd_req), 0);
        check("R10", "reset final", int'(final_data), 0);
        rst_n = 1'b1;
        t_program();
        t_erase();
        t_tmo_recover();
        t_tmo_fail();
        t_budget_fail();
        t_budget_edge();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule